// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Arbiter

This block sits between seven interrupt sources and a processor core. The sources are one power-down request and six external lines. It synchronizes the inputs, latches or follows each one according to its sensing mode, and gates each with its enable bit. It then offers the single most urgent survivor to the core as a 3-bit vector index on a request/acknowledge handshake. Software-facing controls are plain write strobes: an enable mask, a control word (per-line sensing choice and nesting), a write-only force/clear strobe for latched requests, and global enable/disable commands.

A small stack records the vector of every acknowledged handler, so the block knows which handler is running. With nesting off, nothing is offered while any handler is active. With nesting on, only a strictly more urgent vector can preempt. A return strobe pops the stack.

A three-state machine governs the handshake. `ST_OPEN` is the resting state and no request is visible. `ST_OFFER` presents the request. `ST_HOLD` is the one-cycle blackout after an enable-mask write. The transitions are:
- OPEN→HOLD on a mask write, and OPEN→OFFER when a candidate exists.
- OFFER→HOLD on a mask write, and OFFER→OPEN on acknowledge or when the candidate vanishes.
- HOLD→HOLD on another mask write, HOLD→OFFER with a candidate, and HOLD→OPEN without one.

Top module: `irq_arbiter`

## Requirements
- R1: After reset there is no request, the depth is 0, the overflow flag is 0, and the global enable is on. All lines are disabled (mask 0), the programmable lines sense levels, and nesting is off.
- R2: Vector 0 (power-down) is most urgent, then 1 through 6 in order. Line `ext_irq[k-1]` feeds vector k. Among eligible sources the lowest vector is offered.
- R3: Mask bit k-1 set to 1 enables vector k, and a disabled vector is never offered. Vector 0 ignores the mask.
- R4: A mask write makes `irq_req` low in exactly the cycle that follows it. The request returns in the cycle after that if a candidate still exists.
- R5: Vectors 2 and 3 always sense levels. Vectors 0 and 4 always latch rising edges. Control bits 0, 1 and 2 select edge (1) or level (0) sensing for vectors 1, 5 and 6 respectively. A latched request persists after its input falls, and a level request follows its input.
- R6: An acknowledge while `irq_req` is high clears the latch of the offered edge source. An acknowledge with no request has no effect.
- R7: A force/clear write sets (`fc_set` bit k-1) or clears (`fc_clr` bit k-1) the latch of vector k, and clear wins over set. The write has no effect on a source sensing levels.
- R8: `gie_disable` blocks all offers including power-down, and `gie_enable` restores them. Disable wins when both are pulsed together.
- R9: With control bit 3 at 0 (nesting off), nothing is offered while the depth is non-zero.
- R10: With control bit 3 at 1, a request is offered at non-zero depth only if its vector is lower than the vector on top of the stack.
- R11: An acknowledge pushes and increments the depth. `irq_rti` pops and decrements it. A return at depth 0 leaves the depth at 0.
- R12: An acknowledge at full depth sets a sticky overflow flag and leaves the depth unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pd_req | input | 1 | power-down request, rising-edge sensed |
| ext_irq | input | 6 | external lines, bit k-1 is vector k |
| mask_we | input | 1 | enable-mask write strobe |
| mask_wdata | input | 6 | new mask, bit k-1 enables vector k |
| ctl_we | input | 1 | control write strobe |
| ctl_wdata | input | 4 | bits 0..2 edge select for vectors 1/5/6, bit 3 nesting |
| fc_we | input | 1 | force/clear write strobe |
| fc_set | input | 6 | latch set per external vector |
| fc_clr | input | 6 | latch clear per external vector |
| gie_enable | input | 1 | global enable command |
| gie_disable | input | 1 | global disable command |
| irq_ack | input | 1 | core accepts offered vector |
| irq_rti | input | 1 | core returns from handler |
| irq_req | output | 1 | request to core |
| irq_vec | output | 3 | offered vector, 0 when idle |
| nest_depth | output | $clog2(STACK_DEPTH+1) | active handler count |
| stack_ovf | output | 1 | sticky stack overflow |

## Verification
The assertions assume that the core raises `irq_ack` only while `irq_req` is high. They also assume that `irq_rti` never coincides with an acknowledge, and that every input changes only away from the clock edge. The bench drives every strobe for exactly one cycle on the falling edge. It acknowledges only after observing a request, and it issues returns only at idle handshake moments. External lines are held for several cycles so that the synchronizer sees every pulse.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_SRC      = 7;
    localparam int VEC_W        = 3;
    localparam int CTL_W        = 4;
    localparam int CTL_NEST_BIT = 3;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        SENSE_EDGE,
        SENSE_LEVEL,
        SENSE_PROG
    } sense_e;

    typedef enum logic [1:0] {
        ST_OPEN,
        ST_OFFER,
        ST_HOLD
    } arb_state_e;

    // sensing kind of each vector slot
    function automatic sense_e sense_of(input int idx);
        case (idx)
            0, 4:    return SENSE_EDGE;
            2, 3:    return SENSE_LEVEL;
            default: return SENSE_PROG;
        endcase
    endfunction

    // control bit that selects the sensing of a programmable slot
    function automatic int prog_bit(input int idx);
        case (idx)
            5:       return 1;
            6:       return 2;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int NUM_SRC = 7,
    parameter int VEC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic [NUM_SRC-1:0] rise,
    input  logic               ack_fire,
    input  logic [VEC_W-1:0]   ack_vec,
    input  logic               fc_we,
    input  logic [NUM_SRC-1:0] fc_set,
    input  logic [NUM_SRC-1:0] fc_clr,
    output logic [NUM_SRC-1:0] pend_q
);
    logic [NUM_SRC-1:0] pend_d;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_latch
        logic ack_hit;
        assign ack_hit   = ack_fire && (ack_vec == VEC_W'(g));
        // acknowledge clears, a fresh edge sets, force sets, clear has the last word
        assign pend_d[g] = edge_mode[g]
                         & (((pend_q[g] & ~ack_hit) | rise[g] | (fc_we & fc_set[g]))
                            & ~(fc_we & fc_clr[g]));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= pend_d[g];
        end
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NUM_SRC = 7,
    parameter int VEC_W   = 3
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               valid,
    output logic [VEC_W-1:0]   vec
);
    always_comb begin
        valid = 1'b0;
        vec   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                vec   = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
    parameter int DEPTH   = 12,
    parameter int VEC_W   = 3,
    localparam int DEPTH_W = $clog2(DEPTH + 1),
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [VEC_W-1:0]   push_vec,
    input  logic               pop,
    output logic [DEPTH_W-1:0] depth_q,
    output logic [VEC_W-1:0]   top_vec,
    output logic               ovf_q
);
    logic [VEC_W-1:0] slot_q [DEPTH];
    logic             full;
    logic             empty;

    assign full    = (depth_q == DEPTH_W'(DEPTH));
    assign empty   = (depth_q == '0);
    assign top_vec = empty ? '0 : slot_q[IDX_W'(depth_q - 1'b1)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            ovf_q   <= 1'b0;
        end else if (push) begin
            if (full) ovf_q   <= 1'b1;
            else      depth_q <= depth_q + 1'b1;
        end else if (pop && !empty) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (push && !full && (depth_q == DEPTH_W'(s)))
                slot_q[s] <= push_vec;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STACK_DEPTH = 12,
    localparam int NUM_EXT = NUM_SRC - 1,
    localparam int DEPTH_W = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_req,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic               mask_we,
    input  logic [NUM_EXT-1:0] mask_wdata,
    input  logic               ctl_we,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic               fc_we,
    input  logic [NUM_EXT-1:0] fc_set,
    input  logic [NUM_EXT-1:0] fc_clr,
    input  logic               gie_enable,
    input  logic               gie_disable,
    input  logic               irq_ack,
    input  logic               irq_rti,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [DEPTH_W-1:0] nest_depth,
    output logic               stack_ovf
);
    logic [NUM_EXT-1:0] mask_q;
    logic [CTL_W-1:0]   ctl_q;
    logic               gie_q;
    logic               gie_d;
    logic               nest_on;

    logic [NUM_SRC-1:0] raw_in;
    logic [NUM_SRC-1:0] lvl;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] edge_mode;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] src_act;
    logic [NUM_SRC-1:0] enabled;
    logic [NUM_SRC-1:0] allowed;
    logic [NUM_SRC-1:0] cand_req;

    logic               cand_valid;
    vec_t               cand_vec;
    vec_t               top_vec;
    logic               ack_fire;
    logic               rti_fire;

    arb_state_e         state_q;
    arb_state_e         state_d;

    // ---------------- configuration registers ----------------
    always_comb begin
        gie_d = gie_q;
        if (gie_enable)  gie_d = 1'b1;
        if (gie_disable) gie_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctl_q  <= '0;
            gie_q  <= 1'b1;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            if (ctl_we)  ctl_q  <= ctl_wdata;
            gie_q <= gie_d;
        end
    end

    assign nest_on = ctl_q[CTL_NEST_BIT];

    // ---------------- source conditioning ----------------
    assign raw_in = {ext_irq, pd_req};

    irqc_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .level (lvl),
        .rise  (rise)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mode
        if (sense_of(g) == SENSE_EDGE) begin : g_edge
            assign edge_mode[g] = 1'b1;
        end else if (sense_of(g) == SENSE_LEVEL) begin : g_level
            assign edge_mode[g] = 1'b0;
        end else begin : g_prog
            assign edge_mode[g] = ctl_q[prog_bit(g)];
        end
    end

    irqc_pending #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W)
    ) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_mode (edge_mode),
        .rise      (rise),
        .ack_fire  (ack_fire),
        .ack_vec   (irq_vec),
        .fc_we     (fc_we),
        .fc_set    ({fc_set, 1'b0}),
        .fc_clr    ({fc_clr, 1'b0}),
        .pend_q    (pend_q)
    );

    // ---------------- qualification ----------------
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        assign src_act[g] = edge_mode[g] ? pend_q[g] : lvl[g];
        if (g == 0) begin : g_nmi
            assign enabled[g] = 1'b1;
        end else begin : g_masked
            assign enabled[g] = mask_q[g-1];
        end
        assign allowed[g]  = (nest_depth == '0) || (nest_on && (VEC_W'(g) < top_vec));
        assign cand_req[g] = src_act[g] & enabled[g] & allowed[g] & gie_q;
    end

    irqc_prio #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W)
    ) u_prio (
        .req   (cand_req),
        .valid (cand_valid),
        .vec   (cand_vec)
    );

    // ---------------- handshake state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (mask_we)         state_d = ST_HOLD;
                else if (cand_valid) state_d = ST_OFFER;
            end
            ST_OFFER: begin
                if (mask_we)                       state_d = ST_HOLD;
                else if (ack_fire || !cand_valid)  state_d = ST_OPEN;
            end
            ST_HOLD: begin
                if (mask_we)         state_d = ST_HOLD;
                else if (cand_valid) state_d = ST_OFFER;
                else                 state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        irq_req = 1'b0;
        irq_vec = '0;
        unique case (state_q)
            ST_OFFER: begin
                irq_req = cand_valid;
                irq_vec = cand_valid ? cand_vec : '0;
            end
            ST_OPEN, ST_HOLD: begin
                irq_req = 1'b0;
                irq_vec = '0;
            end
            default: begin
                irq_req = 1'b0;
                irq_vec = '0;
            end
        endcase
    end

    assign ack_fire = irq_ack && irq_req;
    assign rti_fire = irq_rti && !ack_fire;

    // ---------------- handler stack ----------------
    irqc_stack #(
        .DEPTH (STACK_DEPTH),
        .VEC_W (VEC_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_fire),
        .push_vec (irq_vec),
        .pop      (rti_fire),
        .depth_q  (nest_depth),
        .top_vec  (top_vec),
        .ovf_q    (stack_ovf)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int STACK_DEPTH = 12,
    parameter int DEPTH_W     = 4,
    parameter int VEC_W       = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mask_we,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               nest_on,
    input logic [DEPTH_W-1:0] depth,
    input logic [VEC_W-1:0]   top_vec,
    input logic               ovf
);
    AST_BLACKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_we) |-> !irq_req); // R4

    AST_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !nest_on) |-> (depth == '0)); // R9

    AST_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && depth != '0) |-> (irq_vec < top_vec)); // R10

    AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (depth != $past(depth)) |-> ((depth == $past(depth) + 1'b1) || (depth + 1'b1 == $past(depth)))); // R11

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DEPTH_W'(STACK_DEPTH)); // R12

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf) |-> ovf); // R12

    AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (depth == DEPTH_W'(STACK_DEPTH))); // R12
endmodule

bind irq_arbiter irqc_checker #(
    .STACK_DEPTH (STACK_DEPTH),
    .DEPTH_W     (DEPTH_W),
    .VEC_W       (irqc_pkg::VEC_W)
) u_irqc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (mask_we),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .nest_on (nest_on),
    .depth   (nest_depth),
    .top_vec (top_vec),
    .ovf     (stack_ovf)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STK        = 4;
    localparam int DW         = $clog2(STK + 1);
    localparam int NONE       = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_req = 1'b0;
    logic [5:0]    ext_irq = '0;
    logic          mask_we = 1'b0;
    logic [5:0]    mask_wdata = '0;
    logic          ctl_we = 1'b0;
    logic [3:0]    ctl_wdata = '0;
    logic          fc_we = 1'b0;
    logic [5:0]    fc_set = '0;
    logic [5:0]    fc_clr = '0;
    logic          gie_enable = 1'b0;
    logic          gie_disable = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq_rti = 1'b0;
    logic          irq_req;
    logic [2:0]    irq_vec;
    logic [DW-1:0] nest_depth;
    logic          stack_ovf;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    irq_arbiter #(.SYNC_STAGES(2), .STACK_DEPTH(STK)) u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .ext_irq(ext_irq),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .fc_we(fc_we), .fc_set(fc_set), .fc_clr(fc_clr),
        .gie_enable(gie_enable), .gie_disable(gie_disable),
        .irq_ack(irq_ack), .irq_rti(irq_rti), .irq_req(irq_req), .irq_vec(irq_vec),
        .nest_depth(nest_depth), .stack_ovf(stack_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int seen();
        return irq_req ? int'(irq_vec) : NONE;
    endfunction

    function automatic int lowest(input logic [6:0] v);
        for (int k = 0; k < 7; k++) if (v[k]) return k;
        return NONE;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mask(input logic [5:0] v);
        @(negedge clk); mask_we = 1'b1; mask_wdata = v;
        @(negedge clk); mask_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_fc(input logic [5:0] s, input logic [5:0] c);
        @(negedge clk); fc_we = 1'b1; fc_set = s; fc_clr = c;
        @(negedge clk); fc_we = 1'b0; fc_set = '0; fc_clr = '0;
    endtask

    task automatic do_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic do_rti();
        @(negedge clk); irq_rti = 1'b1;
        @(negedge clk); irq_rti = 1'b0;
    endtask

    task automatic pulse_ext(input int b);
        @(negedge clk); ext_irq[b] = 1'b1;
        idle(3);
        ext_irq[b] = 1'b0;
    endtask

    task automatic pulse_pd();
        @(negedge clk); pd_req = 1'b1;
        idle(3);
        pd_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 request", int'(irq_req), 0);
        chk("R1 depth", int'(nest_depth), 0);
        chk("R1 overflow", int'(stack_ovf), 0);
        // R3: all lines masked at reset, a level line produces nothing
        ext_irq = 6'b000010;
        idle(6);
        chk("R3 masked at reset", seen(), NONE);
        ext_irq = '0;
        wr_mask(6'h3F);
        idle(4);

        // R2 sweep of level patterns on vectors 1,2,3,5,6 with everything enabled
        for (int p = 0; p < 32; p++) begin
            logic [5:0] e;
            e = {p[4], p[3], 1'b0, p[2], p[1], p[0]};
            ext_irq = e;
            idle(6);
            chk($sformatf("R2 pattern %0d", p), seen(), lowest({e, 1'b0}));
        end

        // R3 sweep of all masks with all level lines high
        ext_irq = 6'b110111;
        for (int m = 0; m < 64; m++) begin
            wr_mask(6'(m));
            idle(2);
            chk($sformatf("R3 mask %0d", m), seen(), lowest({6'b110111 & 6'(m), 1'b0}));
        end
        ext_irq = '0;
        wr_mask(6'h3F);
        idle(4);

        // R5/R6 edge line vector 4 latches, ack clears it
        pulse_ext(3);
        idle(6);
        chk("R5 edge held after fall", seen(), 4);
        do_ack();
        chk("R11 depth after ack", int'(nest_depth), 1);
        do_rti();
        chk("R11 depth after return", int'(nest_depth), 0);
        idle(3);
        chk("R6 latch cleared by ack", seen(), NONE);
        do_ack();
        chk("R6 ack without request", int'(nest_depth), 0);

        // R7 force and clear
        wr_fc(6'b001000, 6'b000000);
        idle(3);
        chk("R7 force edge", seen(), 4);
        wr_fc(6'b000000, 6'b001000);
        idle(3);
        chk("R7 clear edge", seen(), NONE);
        wr_fc(6'b000010, 6'b000000);
        idle(3);
        chk("R7 force on level line ignored", seen(), NONE);
        wr_fc(6'b001000, 6'b001000);
        idle(3);
        chk("R7 clear wins", seen(), NONE);

        // R5 programmable sensing: vector 1 and vector 5 in edge mode
        wr_ctl(4'b0011);
        pulse_ext(0);
        idle(6);
        chk("R5 vector1 edge mode", seen(), 1);
        wr_fc(6'b000000, 6'b000001);
        idle(3);
        chk("R5 vector1 cleared", seen(), NONE);
        pulse_ext(4);
        idle(6);
        chk("R5 vector5 edge mode", seen(), 5);
        wr_fc(6'b000000, 6'b010000);
        wr_ctl(4'b0000);
        idle(3);
        chk("R5 back to idle", seen(), NONE);

        // R3 power-down ignores mask, R8 global gate
        wr_mask(6'h00);
        pulse_pd();
        idle(6);
        chk("R3 power-down unmaskable", seen(), 0);
        @(negedge clk); gie_disable = 1'b1;
        @(negedge clk); gie_disable = 1'b0;
        idle(2);
        chk("R8 disable blocks power-down", seen(), NONE);
        @(negedge clk); gie_enable = 1'b1;
        @(negedge clk); gie_enable = 1'b0;
        idle(2);
        chk("R8 enable restores", seen(), 0);
        do_ack();
        do_rti();
        wr_mask(6'h3F);
        wr_fc(6'b001000, 6'b000000);
        @(negedge clk); gie_enable = 1'b1; gie_disable = 1'b1;
        @(negedge clk); gie_enable = 1'b0; gie_disable = 1'b0;
        idle(2);
        chk("R8 disable wins", seen(), NONE);
        @(negedge clk); gie_enable = 1'b1;
        @(negedge clk); gie_enable = 1'b0;
        idle(2);
        chk("R8 re-enabled", seen(), 4);
        wr_fc(6'b000000, 6'b001000);

        // R4 blackout after mask write
        ext_irq = 6'b000010;
        idle(6);
        chk("R4 before write", seen(), 2);
        @(negedge clk); mask_we = 1'b1; mask_wdata = 6'h3F;
        @(negedge clk); mask_we = 1'b0;
        chk("R4 blackout cycle", seen(), NONE);
        @(negedge clk);
        chk("R4 request returns", seen(), 2);

        // R9 nesting off
        do_ack();
        pulse_pd();
        idle(6);
        chk("R9 no offer while active", seen(), NONE);
        do_rti();
        idle(2);
        chk("R9 power-down after return", seen(), 0);
        do_ack();
        idle(2);
        chk("R9 serial hold", seen(), NONE);
        do_rti();
        idle(2);
        chk("R9 level line next", seen(), 2);
        ext_irq = '0;
        idle(4);

        // R10 nesting on, R12 overflow
        wr_ctl(4'b1000);
        ext_irq = 6'b100000;
        idle(6);
        chk("R10 first handler", seen(), 6);
        do_ack();
        idle(2);
        chk("R10 same vector not re-offered", seen(), NONE);
        ext_irq[2] = 1'b1;
        idle(6);
        chk("R10 preempt by vector 3", seen(), 3);
        do_ack();
        pulse_ext(3);
        idle(6);
        chk("R10 lower vector 4 held off", seen(), NONE);
        ext_irq[1] = 1'b1;
        idle(6);
        chk("R10 preempt by vector 2", seen(), 2);
        do_ack();
        ext_irq[0] = 1'b1;
        idle(6);
        chk("R10 preempt by vector 1", seen(), 1);
        do_ack();
        chk("R11 depth full", int'(nest_depth), STK);
        pulse_pd();
        idle(6);
        chk("R10 power-down at full depth", seen(), 0);
        do_ack();
        chk("R12 overflow flag", int'(stack_ovf), 1);
        chk("R12 depth unchanged", int'(nest_depth), STK);
        for (int d = STK - 1; d >= 0; d--) begin
            do_rti();
            chk($sformatf("R11 pop to %0d", d), int'(nest_depth), d);
        end
        do_rti();
        chk("R11 return at zero", int'(nest_depth), 0);
        chk("R12 overflow sticky", int'(stack_ovf), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule